// File: doc/BRIEF.md
# Interrupt Pending Latch

This block keeps the pending state of every interrupt line of a small interrupt controller and turns it into one request toward the processor core. Each line has its own trigger mode. A level line counts as pending for exactly as long as its synchronized source is high. A pulse line latches a rising edge into a sticky flag, and only a software clear strobe for that line removes the flag. All source inputs pass through a multi-flop synchronizer before any of this logic sees them, so a pulse is only seen if it is high across at least one rising clock edge.

The request is gated by a global enable and by a handler-active flag. The core accepts a request with a take strobe, which marks a handler as running. From then on the request stays low until a return strobe ends the handler. Lines that become pending while the handler runs stay pending. They raise the request again once the handler has returned and the enable is high. When several lines are pending at once, the lowest-numbered one is reported as the request identifier.

Top module: `irq_pend_latch`

## Requirements
- R1: After a synchronous reset, every pending flag reads 0, the handler-active flag reads 0 and the request output is low.
- R2: A line with mode bit 0 (level) shows pending on the second rising edge after its source first reads high. It drops on the second edge after the source goes low, and its clear strobe has no effect on it.
- R3: If a level line is still high while the global enable is low, the request rises in the same cycle that the enable goes high, with no clock edge in between.
- R4: On a line with mode bit 1 (pulse), a source that is high across one clock edge sets the pending flag on the third edge. The flag stays set after the source falls and is removed on the edge where that line's clear strobe is high.
- R5: A pulse-line source that goes high and low again without spanning a rising clock edge sets no pending flag.
- R6: If a pulse line's clear strobe falls on the same edge that registers a new rising edge of that line, the line stays pending.
- R7: The request is high exactly when the enable is high, no handler is active and at least one line is pending. The request identifier is then the index of the lowest-numbered pending line.
- R8: A take strobe while the request is high makes the handler active on that edge and holds the request low. Lines that become pending during the handler stay pending, and the request returns, with the lowest such line, on the edge after the return strobe.
- R9: A take strobe while the request is low leaves the handler inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_LINES | Asynchronous interrupt source lines |
| mode_i | input | NUM_LINES | Per-line trigger mode: 0 level, 1 pulse |
| clr_i | input | NUM_LINES | Per-line software clear strobe |
| gie_i | input | 1 | Global interrupt enable |
| take_i | input | 1 | Core accepts the current request; handler starts |
| ret_i | input | 1 | Handler return strobe |
| pend_o | output | NUM_LINES | Per-line pending flags |
| irq_o | output | 1 | Interrupt request toward the core |
| irq_id_o | output | ID_W | Index of the lowest pending line |
| active_o | output | 1 | Handler-active flag |

## Verification
The bench goes after the edges of the timing windows. It checks that a level line's clear strobe is ignored, and a design that latched level lines would keep them pending after the source falls. It checks that a pulse falling between two clock edges is dropped, which a design sampling the raw input asynchronously would catch. It checks that a clear coinciding with a fresh edge keeps the line pending, and a design that gives the clear priority would lose that interrupt for good. The bench also re-enables interrupts with a level source still high, and fires a new pulse while a handler is active. A design with a registered request or a leaky active gate would show the request one cycle late there, or show it during the handler.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int MAX_LINES = 32;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_PULSE = 1'b1
    } trig_e;

    typedef struct packed {
        logic seen;    // synchronized level of the previous cycle
        logic sticky;  // latched pulse flag
    } line_state_t;

    // Index of the lowest set bit; 0 when none is set.
    function automatic logic [4:0] lowest_set(input logic [MAX_LINES-1:0] vec);
        logic [4:0] idx;
        idx = '0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (vec[i]) idx = 5'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_pend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);
    line_state_t st_q, st_d;
    trig_e       trig;
    logic        rise;

    assign trig = trig_e'(mode_i);
    assign rise = lvl_i & ~st_q.seen;

    always_comb begin
        st_d.seen = lvl_i;
        if (trig == TRIG_PULSE) st_d.sticky = rise | (st_q.sticky & ~clr_i);
        else                    st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_o = (trig == TRIG_PULSE) ? st_q.sticky : lvl_i;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pend_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] pend_i,
    output logic                 any_o,
    output logic [ID_W-1:0]      id_o
);
    logic [MAX_LINES-1:0] wide;
    logic [4:0]           idx;

    assign wide  = MAX_LINES'(pend_i);
    assign idx   = lowest_set(wide);
    assign any_o = |pend_i;
    assign id_o  = idx[ID_W-1:0];
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
    import irq_pend_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] src_i,
    input  logic [NUM_LINES-1:0] mode_i,
    input  logic [NUM_LINES-1:0] clr_i,
    input  logic                 gie_i,
    input  logic                 take_i,
    input  logic                 ret_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic                 irq_o,
    output logic [ID_W-1:0]      irq_id_o,
    output logic                 active_o
);
    logic [NUM_LINES-1:0] lvl;
    logic                 any_pend;
    logic                 active_q;

    irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (lvl)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_cell i_cell (
            .clk    (clk),
            .rst    (rst),
            .mode_i (mode_i[g]),
            .lvl_i  (lvl[g]),
            .clr_i  (clr_i[g]),
            .pend_o (pend_o[g])
        );
    end

    irq_pick #(.NUM_LINES(NUM_LINES)) i_pick (
        .pend_i (pend_o),
        .any_o  (any_pend),
        .id_o   (irq_id_o)
    );

    assign irq_o = gie_i & ~active_q & any_pend;

    always_ff @(posedge clk) begin
        if (rst)           active_q <= 1'b0;
        else if (active_q) active_q <= ~ret_i;
        else               active_q <= take_i & irq_o;
    end

    assign active_o = active_q;
endmodule

// File: rtl/irq_pend_latch_chk.sv
module irq_pend_latch_chk #(
    parameter int NUM_LINES = 8,
    localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] mode_i,
    input logic [NUM_LINES-1:0] clr_i,
    input logic                 gie_i,
    input logic                 take_i,
    input logic                 ret_i,
    input logic [NUM_LINES-1:0] pend_o,
    input logic                 irq_o,
    input logic [ID_W-1:0]      irq_id_o,
    input logic                 active_o
);
    logic [NUM_LINES-1:0] below;
    assign below = (NUM_LINES'(1) << irq_id_o) - NUM_LINES'(1);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pend_o == '0 && !active_o)); // R1
    AST_ID_LOWEST: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_o[irq_id_o] && (pend_o & below) == '0)); // R7
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst) irq_o |-> gie_i); // R7
    AST_TAKE_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        (take_i && irq_o) |=> active_o); // R8
    AST_ACTIVE_MUTES: assert property (@(posedge clk) disable iff (rst) active_o |-> !irq_o); // R8
    AST_RET_ENDS: assert property (@(posedge clk) disable iff (rst)
        (active_o && ret_i) |=> !active_o); // R8
    AST_IDLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        (!active_o && !irq_o && take_i) |=> !active_o); // R9

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (rst)
            (mode_i[g] && pend_o[g] && !clr_i[g]) |=> (pend_o[g] || !mode_i[g])); // R4
    end
endmodule

bind irq_pend_latch irq_pend_latch_chk #(.NUM_LINES(NUM_LINES)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .clr_i    (clr_i),
    .gie_i    (gie_i),
    .take_i   (take_i),
    .ret_i    (ret_i),
    .pend_o   (pend_o),
    .irq_o    (irq_o),
    .irq_id_o (irq_id_o),
    .active_o (active_o)
);

// File: tb/test_irq_pend_latch.sv
module test_irq_pend_latch;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int IDW = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   src, mode, clr;
    logic           gie, take, ret;
    logic [N-1:0]   pend;
    logic           irq, active;
    logic [IDW-1:0] irq_id;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_latch #(.NUM_LINES(N), .SYNC_STAGES(2)) i_irq_pend_latch (
        .clk(clk), .rst(rst), .src_i(src), .mode_i(mode), .clr_i(clr),
        .gie_i(gie), .take_i(take), .ret_i(ret),
        .pend_o(pend), .irq_o(irq), .irq_id_o(irq_id), .active_o(active)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Pulse one line high across exactly one edge, wait until latched.
    task automatic fire(input int ln);
        src[ln] = 1'b1;
        step(1);
        src[ln] = 1'b0;
        step(2);
    endtask

    task automatic t_reset;
        check("R1 pend", 32'(pend), 32'h0);
        check("R1 active", 32'(active), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_level;
        src[2] = 1'b1;
        step(1);
        check("R2 level not yet", 32'(pend[2]), 32'h0);
        step(1);
        check("R2 level pending", 32'(pend[2]), 32'h1);
        clr[2] = 1'b1;
        step(1);
        clr[2] = 1'b0;
        check("R2 clear ignored", 32'(pend[2]), 32'h1);
        src[2] = 1'b0;
        step(1);
        check("R2 level holds one edge", 32'(pend[2]), 32'h1);
        step(1);
        check("R2 level drops", 32'(pend[2]), 32'h0);
    endtask

    task automatic t_reenable;
        gie = 1'b0;
        src[5] = 1'b1;
        step(3);
        check("R3 masked", 32'(irq), 32'h0);
        gie = 1'b1;
        #1;
        check("R3 immediate request", 32'(irq), 32'h1);
        check("R7 id level", 32'(irq_id), 32'd5);
        src[5] = 1'b0;
        step(2);
        check("R3 source gone", 32'(irq), 32'h0);
        gie = 1'b0;
    endtask

    task automatic t_pulse;
        src[1] = 1'b1;
        step(1);
        src[1] = 1'b0;
        step(1);
        check("R4 not yet", 32'(pend[1]), 32'h0);
        step(1);
        check("R4 latched", 32'(pend[1]), 32'h1);
        step(5);
        check("R4 sticky", 32'(pend[1]), 32'h1);
        clr[1] = 1'b1;
        step(1);
        clr[1] = 1'b0;
        check("R4 cleared", 32'(pend[1]), 32'h0);
    endtask

    task automatic t_short;
        src[4] = 1'b1;
        #2;
        src[4] = 1'b0;
        step(4);
        check("R5 short pulse dropped", 32'(pend[4]), 32'h0);
    endtask

    task automatic t_race;
        fire(6);
        check("R6 first pending", 32'(pend[6]), 32'h1);
        src[6] = 1'b1;
        step(2);
        clr[6] = 1'b1;
        step(1);
        clr[6] = 1'b0;
        check("R6 edge beats clear", 32'(pend[6]), 32'h1);
        src[6] = 1'b0;
        clr[6] = 1'b1;
        step(1);
        clr[6] = 1'b0;
        check("R4 plain clear", 32'(pend[6]), 32'h0);
    endtask

    task automatic t_handler;
        gie = 1'b1;
        src[3] = 1'b1;
        src[7] = 1'b1;
        step(1);
        src[3] = 1'b0;
        src[7] = 1'b0;
        step(2);
        check("R7 request", 32'(irq), 32'h1);
        check("R7 lowest id", 32'(irq_id), 32'd3);
        take = 1'b1;
        step(1);
        take = 1'b0;
        check("R8 active", 32'(active), 32'h1);
        check("R8 muted", 32'(irq), 32'h0);
        fire(1);
        check("R8 held pending", 32'(pend[1]), 32'h1);
        check("R8 still muted", 32'(irq), 32'h0);
        ret = 1'b1;
        step(1);
        ret = 1'b0;
        check("R8 returned", 32'(active), 32'h0);
        check("R8 serviced after return", 32'(irq), 32'h1);
        check("R7 new lowest id", 32'(irq_id), 32'd1);
        clr = '1;
        step(1);
        clr = '0;
        check("R4 all cleared", 32'(pend), 32'h0);
    endtask

    task automatic t_take_idle;
        gie = 1'b1;
        take = 1'b1;
        step(1);
        take = 1'b0;
        check("R9 idle take", 32'(active), 32'h0);
        gie = 1'b0;
        fire(0);
        check("R7 gated by enable", 32'(irq), 32'h0);
        take = 1'b1;
        step(1);
        take = 1'b0;
        check("R9 masked take", 32'(active), 32'h0);
        clr[0] = 1'b1;
        step(1);
        clr[0] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        src = '0;
        clr = '0;
        mode = 8'b1101_1011;
        gie = 1'b0;
        take = 1'b0;
        ret = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
        t_reset();
        t_level();
        t_reenable();
        t_pulse();
        t_short();
        t_race();
        t_handler();
        t_take_idle();
        summary();
    end
endmodule